// File: doc/BRIEF.md
# Single-Wire Slave Bit Timing Engine

This block is the slave end of the physical layer of a single-wire, open-drain bus. It runs on a system clock whose rate in cycles per microsecond is a parameter. It watches the bus level and controls one output that pulls the bus low. It recognises a long master low as a bus reset, strobes that to the upper layer, and answers with a presence pulse. Short lows start time slots. In a write slot the bus level is sampled at a fixed point inside the slot and becomes one data bit. In a read slot the block either holds the bus low or leaves it released, so that the master sees the bit the upper layer queued.

Received bits are collected into bytes, least significant bit first, and each finished byte is handed up with a one-cycle valid strobe. To send, the upper layer offers a byte with a valid/ready handshake. While a sent byte is pending, the next eight slots are handled as read slots. A bus reset throws away any byte in progress in either direction.

The control is one state machine with seven states. `ST_IDLE` waits for a falling edge. A falling edge goes to `ST_RDRV` if a byte is pending for transmission, and to `ST_WSAMP` otherwise. `ST_WSAMP` goes to `ST_WAITHI` at the sample point, after pushing the sampled bit. `ST_RDRV` goes to `ST_WAITHI` when its hold time runs out, after advancing the transmit bit. `ST_WAITHI` goes to `ST_IDLE` once the bus is high. From any state, a reset detection goes to `ST_RSTLOW`. `ST_RSTLOW` goes to `ST_PWAIT` when the bus rises. `ST_PWAIT` goes to `ST_PDRV` after the presence delay. `ST_PDRV` goes to `ST_WAITHI` after the presence length.

Top module: `ow_slave_phy`

## Requirements
- R1: A bus low lasting 480 us or more produces exactly one single-cycle pulse on `bus_rst_o` while the bus is still low. A low of 470 us produces none.
- R2: After the bus rises at the end of a reset low, `pull_o` stays deasserted for 30 us. It is then asserted for 120 us as the presence pulse. It is not asserted 15 us after the rise, it is asserted 70 us after the rise, and it is released 200 us after the rise.
- R3: In a write slot the bus is sampled 30 us after the falling edge. A bus still low at that point is a 0 bit, and a bus already high is a 1 bit. A 20 us low gives 1 and a 45 us low gives 0.
- R4: Received bits fill a byte least significant bit first. After the eighth bit, `rx_byte_o` carries the byte and `rx_valid_o` is high for exactly one cycle.
- R5: In a read slot, the bit sent is the lowest unsent bit of the queued byte. A 0 bit asserts `pull_o` from the detected falling edge for 30 us. A 1 bit leaves `pull_o` low.
- R6: `tx_ready_o` is high only when the engine is idle between bytes with no byte pending. A transfer takes place on `tx_valid_i && tx_ready_o`, after which `tx_ready_o` stays low until eight read slots have completed.
- R7: A bus reset discards a partly received byte and any pending transmit byte. `tx_ready_o` is low from the reset strobe until the presence pulse has ended and the bus is high. The slots after the reset are write slots that start a new byte.
- R8: `pull_o` is asserted only during a presence pulse or while driving a 0 in a read slot. It is never asserted during write slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Sensed level of the shared bus |
| pull_o | output | 1 | Open-drain pull-down enable; 1 drives the bus low |
| rx_byte_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_byte_o` is new |
| tx_byte_i | input | BYTE_W | Byte to send in the coming read slots |
| tx_valid_i | input | 1 | Upper layer offers `tx_byte_i` |
| tx_ready_o | output | 1 | Engine can take a byte to send |
| bus_rst_o | output | 1 | One-cycle strobe on a detected bus reset |

## Verification
The bench places slot lows on both sides of the sample point (20 us and 45 us). A design that sampled too early or too late would flip those bits. It drives lows of 470 us and 500 us. A reset threshold that was off, or a strobe that repeated, would change the count of reset pulses and would wrongly start or suppress a presence pulse. It interrupts a byte with a reset, both partway through a reception and with a transmit byte already queued. A design that kept the stale bit count would misalign the next byte. A design that kept the queued byte would turn the next write slots into read slots and pull the bus during them. Read bytes containing both 0 and 1 bits show bit-order reversal, and show a pull that is missing or has the wrong polarity.

// File: rtl/ow_phy_pkg.sv
package ow_phy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSAMP,
        ST_RDRV,
        ST_WAITHI,
        ST_RSTLOW,
        ST_PWAIT,
        ST_PDRV
    } phy_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ow_bus_sync.sv
module ow_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_i,
    output logic bus_s,
    output logic fall_o
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sh;
    logic         prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= bus_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[MSB-1:0], bus_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= sh[MSB];
    end

    assign bus_s  = sh[MSB];
    assign fall_o = prev & ~sh[MSB];

endmodule

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
    parameter int RST_CYC = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_s,
    output logic rst_hit
);
    localparam int LW = $clog2(RST_CYC + 1);
    localparam logic [LW-1:0] SAT  = LW'(RST_CYC);
    localparam logic [LW-1:0] LAST = LW'(RST_CYC - 1);

    logic [LW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (bus_s)       cnt <= '0;
        else if (cnt != SAT)  cnt <= cnt + 1'b1;
    end

    assign rst_hit = !bus_s && (cnt == LAST);

endmodule

// File: rtl/ow_bit_shift.sv
module ow_bit_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_push,
    input  logic              rx_bit,
    input  logic              tx_adv,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_bit,
    output logic              tx_pend,
    output logic              at_boundary
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_next;

    assign rx_next = {rx_bit, rx_sr[BYTE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_pend  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                cnt     <= '0;
                rx_sr   <= '0;
                tx_pend <= 1'b0;
            end else if (tx_load) begin
                tx_sr   <= tx_byte;
                tx_pend <= 1'b1;
                cnt     <= '0;
            end else if (rx_push) begin
                rx_sr <= rx_next;
                if (cnt == LAST) begin
                    cnt      <= '0;
                    rx_byte  <= rx_next;
                    rx_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (tx_adv) begin
                tx_sr <= {1'b0, tx_sr[BYTE_W-1:1]};
                if (cnt == LAST) begin
                    cnt     <= '0;
                    tx_pend <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign tx_bit      = tx_sr[0];
    assign at_boundary = (cnt == '0);

endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
    import ow_phy_pkg::*;
#(
    parameter int SAMP_CYC  = 60,
    parameter int HOLD_CYC  = 60,
    parameter int PWAIT_CYC = 60,
    parameter int PLEN_CYC  = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_s,
    input  logic fall,
    input  logic rst_hit,
    input  logic tx_pend,
    input  logic tx_bit,
    output logic pull_o,
    output logic rst_o,
    output logic rx_push,
    output logic rx_bit,
    output logic tx_adv,
    output logic clr,
    output logic slot_idle
);
    localparam int TMAX = max_of4(SAMP_CYC, HOLD_CYC, PWAIT_CYC, PLEN_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SAMP_L  = TW'(SAMP_CYC - 1);
    localparam logic [TW-1:0] HOLD_L  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] PWAIT_L = TW'(PWAIT_CYC - 1);
    localparam logic [TW-1:0] PLEN_L  = TW'(PLEN_CYC - 1);

    phy_state_t    state, nxt;
    logic [TW-1:0] tmr;
    logic [TW-1:0] lim;
    logic          tmr_done;

    always_comb begin
        unique case (state)
            ST_WSAMP: lim = SAMP_L;
            ST_RDRV:  lim = HOLD_L;
            ST_PWAIT: lim = PWAIT_L;
            ST_PDRV:  lim = PLEN_L;
            default:  lim = '0;
        endcase
    end

    assign tmr_done = (tmr == lim);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (fall)     nxt = tx_pend ? ST_RDRV : ST_WSAMP;
            ST_WSAMP:  if (tmr_done) nxt = ST_WAITHI;
            ST_RDRV:   if (tmr_done) nxt = ST_WAITHI;
            ST_WAITHI: if (bus_s)    nxt = ST_IDLE;
            ST_RSTLOW: if (bus_s)    nxt = ST_PWAIT;
            ST_PWAIT:  if (tmr_done) nxt = ST_PDRV;
            ST_PDRV:   if (tmr_done) nxt = ST_WAITHI;
            default:                 nxt = ST_IDLE;
        endcase
        if (rst_hit && state != ST_RSTLOW) nxt = ST_RSTLOW;
    end

    // state register and slot timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            state <= nxt;
            tmr   <= (nxt != state) ? '0 : tmr + 1'b1;
        end
    end

    // registered bus-facing outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_o <= 1'b0;
            rst_o  <= 1'b0;
        end else begin
            pull_o <= (nxt == ST_PDRV) || (nxt == ST_RDRV && !tx_bit);
            rst_o  <= rst_hit && (state != ST_RSTLOW);
        end
    end

    assign rx_push   = (state == ST_WSAMP) && tmr_done && !rst_hit;
    assign rx_bit    = bus_s;
    assign tx_adv    = (state == ST_RDRV) && tmr_done && !rst_hit;
    assign clr       = rst_hit;
    assign slot_idle = (state == ST_IDLE);

endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy #(
    parameter int CYC_PER_US  = 50,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RST_US      = 480,
    parameter int SAMP_US     = 30,
    parameter int HOLD_US     = 30,
    parameter int PWAIT_US    = 30,
    parameter int PLEN_US     = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_i,
    output logic              pull_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              bus_rst_o
);
    localparam int RST_CYC   = RST_US   * CYC_PER_US;
    localparam int SAMP_CYC  = SAMP_US  * CYC_PER_US;
    localparam int HOLD_CYC  = HOLD_US  * CYC_PER_US;
    localparam int PWAIT_CYC = PWAIT_US * CYC_PER_US;
    localparam int PLEN_CYC  = PLEN_US  * CYC_PER_US;

    logic bus_s, fall, rst_hit;
    logic rx_push, rx_bit, tx_adv, clr, slot_idle;
    logic tx_bit, tx_pend, at_boundary, tx_load;

    ow_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .bus_s(bus_s), .fall_o(fall)
    );

    ow_low_timer #(.RST_CYC(RST_CYC)) u_low (
        .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .rst_hit(rst_hit)
    );

    ow_slot_fsm #(
        .SAMP_CYC(SAMP_CYC), .HOLD_CYC(HOLD_CYC),
        .PWAIT_CYC(PWAIT_CYC), .PLEN_CYC(PLEN_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .fall(fall), .rst_hit(rst_hit),
        .tx_pend(tx_pend), .tx_bit(tx_bit), .pull_o(pull_o), .rst_o(bus_rst_o),
        .rx_push(rx_push), .rx_bit(rx_bit), .tx_adv(tx_adv), .clr(clr),
        .slot_idle(slot_idle)
    );

    assign tx_ready_o = !tx_pend && slot_idle && at_boundary;
    assign tx_load    = tx_valid_i && tx_ready_o;

    ow_bit_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tx_load(tx_load), .tx_byte(tx_byte_i),
        .rx_push(rx_push), .rx_bit(rx_bit), .tx_adv(tx_adv), .rx_byte(rx_byte_o),
        .rx_valid(rx_valid_o), .tx_bit(tx_bit), .tx_pend(tx_pend),
        .at_boundary(at_boundary)
    );

endmodule

// File: rtl/ow_phy_chk.sv
module ow_phy_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_i,
    input logic pull_o,
    input logic rx_valid_o,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic bus_rst_o
);
    p_rst_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |=> !bus_rst_o);

    p_rst_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |-> !$past(bus_i, 3));

    p_no_pull_at_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |-> !pull_o);

    p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    p_accept_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

    p_rst_blocks_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |-> !tx_ready_o);

    p_rst_no_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |-> !rx_valid_o);
endmodule

bind ow_slave_phy ow_phy_chk chk_i (.*);

// File: tb/ow_slave_phy_tb.sv
`timescale 1ns/1ps
module ow_slave_phy_tb_top;
    localparam int CPU = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_m = 1'b1;
    logic       bus_i;
    logic       pull_o, rx_valid_o, tx_valid_i, tx_ready_o, bus_rst_o;
    logic [7:0] rx_byte_o, tx_byte_i;

    int checks = 0;
    int errors = 0;
    int rst_cnt = 0;
    int rx_cnt = 0;
    int wr_pull = 0;
    logic mon_wr = 1'b0;
    logic [7:0] last_rx = '0;

    always #2 clk = ~clk;

    assign bus_i = bus_m & ~pull_o;

    ow_slave_phy #(.CYC_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .pull_o(pull_o),
        .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .tx_byte_i(tx_byte_i),
        .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .bus_rst_o(bus_rst_o)
    );

    always @(posedge clk) begin
        if (bus_rst_o) rst_cnt <= rst_cnt + 1;
        if (rx_valid_o) begin
            rx_cnt  <= rx_cnt + 1;
            last_rx <= rx_byte_o;
        end
        if (mon_wr && pull_o) wr_pull <= wr_pull + 1;
    end

    // stimulus vectors: bit 8 set = read byte from slave, clear = write byte to slave
    localparam logic [8:0] VEC [0:5] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h081, 9'h17E};

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic low_for(input int n);
        bus_m = 1'b0;
        wait_us(n);
        bus_m = 1'b1;
    endtask

    task automatic write_bit_w(input int low_us);
        low_for(low_us);
        wait_us(75 - low_us);
    endtask

    task automatic write_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) write_bit_w(b[i] ? 6 : 60);
    endtask

    task automatic read_bit(output logic b);
        low_for(1);
        wait_us(14);
        b = bus_i;
        wait_us(60);
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic v;
            read_bit(v);
            b[i] = v;
        end
    endtask

    task automatic bus_reset(input string req);
        int r0;
        r0 = rst_cnt;
        low_for(500);
        chk(rst_cnt == r0 + 1, req, rst_cnt - r0, 1);
        wait_us(15);
        chk(pull_o == 1'b0, "R2 presence delay", pull_o, 0);
        wait_us(55);
        chk(pull_o == 1'b1, "R2 presence active", pull_o, 1);
        wait_us(130);
        chk(pull_o == 1'b0, "R2 presence released", pull_o, 0);
        wait_us(10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int r0, c0;
        tx_valid_i = 1'b0;
        tx_byte_i  = '0;
        repeat (5) @(negedge clk);
        chk(pull_o == 1'b0, "R8 reset pull", pull_o, 0);
        chk(bus_rst_o == 1'b0, "R1 reset strobe", bus_rst_o, 0);
        chk(rx_valid_o == 1'b0, "R4 reset valid", rx_valid_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_ready_o == 1'b1, "R6 ready after reset", tx_ready_o, 1);

        bus_reset("R1 reset detect");

        // vector table
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][8]) begin
                chk(tx_ready_o == 1'b1, "R6 ready idle", tx_ready_o, 1);
                tx_byte_i  = VEC[v][7:0];
                tx_valid_i = 1'b1;
                @(negedge clk);
                tx_valid_i = 1'b0;
                chk(tx_ready_o == 1'b0, "R6 ready drop", tx_ready_o, 0);
                c0 = rx_cnt;
                read_byte(got);
                chk(got == VEC[v][7:0], "R5 read byte", got, VEC[v][7:0]);
                chk(rx_cnt == c0, "R6 no rx during read", rx_cnt - c0, 0);
                chk(tx_ready_o == 1'b1, "R6 ready after byte", tx_ready_o, 1);
            end else begin
                c0 = rx_cnt;
                wr_pull = 0;
                mon_wr = 1'b1;
                write_byte(VEC[v][7:0]);
                mon_wr = 1'b0;
                chk(rx_cnt == c0 + 1, "R4 one valid", rx_cnt - c0, 1);
                chk(last_rx == VEC[v][7:0], "R4 write byte", last_rx, VEC[v][7:0]);
                chk(wr_pull == 0, "R8 no pull in write", wr_pull, 0);
            end
        end

        // R3 sample point boundary: lows 20,45,20,45,45,45,20,20 -> 0xC5
        c0 = rx_cnt;
        write_bit_w(20); write_bit_w(45); write_bit_w(20); write_bit_w(45);
        write_bit_w(45); write_bit_w(45); write_bit_w(20); write_bit_w(20);
        chk(rx_cnt == c0 + 1 && last_rx == 8'hC5, "R3 sample point", last_rx, 8'hC5);

        // R1 short low ignored
        r0 = rst_cnt;
        low_for(470);
        chk(rst_cnt == r0, "R1 470us ignored", rst_cnt - r0, 0);
        wait_us(70);
        chk(pull_o == 1'b0, "R1 no presence after short low", pull_o, 0);
        wait_us(100);
        bus_reset("R1 realign reset");

        // R7 partial byte aborted
        write_bit_w(6); write_bit_w(60); write_bit_w(6);
        bus_reset("R7 reset mid byte");
        c0 = rx_cnt;
        write_byte(8'h5A);
        chk(rx_cnt == c0 + 1, "R7 single byte after abort", rx_cnt - c0, 1);
        chk(last_rx == 8'h5A, "R7 realigned byte", last_rx, 8'h5A);

        // R7 pending tx dropped
        tx_byte_i  = 8'h00;
        tx_valid_i = 1'b1;
        @(negedge clk);
        tx_valid_i = 1'b0;
        chk(tx_ready_o == 1'b0, "R6 accepted", tx_ready_o, 0);
        bus_reset("R7 reset with tx pending");
        chk(tx_ready_o == 1'b1, "R7 ready after presence", tx_ready_o, 1);
        c0 = rx_cnt;
        wr_pull = 0;
        mon_wr = 1'b1;
        write_byte(8'h33);
        mon_wr = 1'b0;
        chk(wr_pull == 0, "R7 tx dropped no pull", wr_pull, 0);
        chk(rx_cnt == c0 + 1 && last_rx == 8'h33, "R7 write after drop", last_rx, 8'h33);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule